// File: doc/BRIEF.md
# Language Card Bank Switch Controller

This block tracks the mode of a 16 KB bank-switched RAM card from the accesses a processor makes into its I/O page. Sixteen switch addresses sit in one 16-byte window of that page. Any access to one of them changes three flags:

- which 4 KB bank is mapped at the low part of the card window;
- whether reads come from the card RAM or from ROM;
- whether writes to the card RAM are allowed.

Either a read or a write triggers the switch. The address alone carries the command. Data is never looked at.

Write permission is protected against a single stray access. An address that arms writing grants it only when one of two things holds:

- writing is already allowed; or
- the previous I/O-page access in the same direction (read or write) hit the same switch. Address bits 2 and 3 are not compared for this.

The controller keeps a separate last-address record for reads and for writes. Each record takes every access to the I/O page, whether or not it is a switch. Two status bytes give the bank and read-source flags in bit 7, in the form a status read returns. The address decoder that maps memory uses the three flags.

The mode is held as a four-state machine over the read source and the write permission. The bank bit is a separate register.

The states are:

- `ST_ROM_PROT`: ROM read, writes blocked.
- `ST_RAM_PROT`: RAM read, writes blocked.
- `ST_ROM_WREN`: ROM read, writes allowed.
- `ST_RAM_WREN`: RAM read, writes allowed.

The transitions are:

- `T_PROTECT`: any protect command moves to a `*_PROT` state.
- `T_ARM_FIRST`: an arm command with no matching history and writes blocked moves to a `*_PROT` state.
- `T_ARM_REPEAT`: an arm command whose history matches moves to a `*_WREN` state.
- `T_HOLD_WE`: an arm command while writes are already allowed stays in a `*_WREN` state, with the read source taken from the command.

Reset enters `ST_ROM_PROT` with bank 1 selected.

Top module: `lcsw_ctrl`

## Requirements
- R1: On a switch access, address bit 3 picks the bank: 1 selects bank 1 (`bank_one`=1), 0 selects bank 2. Address bit 2 does not take part in decoding.
- R2: On a switch access, address bits [1:0] of 00 or 11 select RAM reads (`ram_read_en`=1), and 01 or 10 select ROM reads.
- R3: A switch access with bits [1:0] of 00 or 10 clears `ram_write_en` at the next clock edge.
- R4: A switch access with bits [1:0] of 01 or 11 sets `ram_write_en` if it is already set. It also sets it if the previous I/O-page access in the same direction has the same low address byte under the mask 0xF3. Otherwise `ram_write_en` stays cleared.
- R5: Read history and write history are kept apart. An access in one direction neither completes nor breaks an arming sequence in the other direction.
- R6: Every valid access whose address lies in page 0xC0 is recorded in its direction's history, switch or not. An access outside the page is not recorded.
- R7: A valid access outside 0xC080–0xC08F leaves all three flags unchanged, as does any cycle with `acc_valid` low.
- R8: After reset, `bank_one`=1, `ram_read_en`=0 and `ram_write_en`=0.
- R9: `stat_bank` is 0x80 when bank 2 is selected and 0x00 otherwise. `stat_ram_rd` is 0x80 when RAM reads are selected and 0x00 otherwise.
- R10: Flags change on the clock edge that samples the access, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access direction: 1 write, 0 read |
| acc_addr | input | 16 | Access address |
| bank_one | output | 1 | 1: bank 1 selected, 0: bank 2 |
| ram_read_en | output | 1 | Reads of the card window come from RAM |
| ram_write_en | output | 1 | Writes to the card RAM are allowed |
| stat_bank | output | 8 | Bank status byte, bit 7 set for bank 2 |
| stat_ram_rd | output | 8 | Read-source status byte, bit 7 set for RAM |

## Verification
The bench builds the block with its default parameters:

- a 16-bit address;
- I/O page 0xC0;
- switch window nibble 0x8;
- history mask 0xF3;
- 8-bit status bytes.

With these values, literal switch addresses and their aliases through bits 2 and 3 can be driven directly. Sequences interleave reads and writes, non-switch page accesses, and accesses off the page. These test the masked compare and the split histories against a behavioural model on every clock.

// File: rtl/lcsw_pkg.sv
package lcsw_pkg;

    // Mode of the card: read source x write permission
    typedef enum logic [1:0] {
        ST_ROM_PROT = 2'd0,
        ST_RAM_PROT = 2'd1,
        ST_ROM_WREN = 2'd2,
        ST_RAM_WREN = 2'd3
    } lc_state_e;

    // Command carried in address bits [1:0]
    typedef enum logic [1:0] {
        OP_RAM_WP  = 2'b00,
        OP_ROM_ARM = 2'b01,
        OP_ROM_WP  = 2'b10,
        OP_RAM_ARM = 2'b11
    } lc_op_e;

    typedef struct packed {
        logic       io_hit;   // address lies in the I/O page
        logic       sw_hit;   // address lies in the switch window
        logic       bank_sel; // bit 3 of the address
        lc_op_e     op;       // bits [1:0]
        logic [7:0] key;      // low address byte kept in history
    } lc_dec_t;

endpackage

// File: rtl/lcsw_decode.sv
module lcsw_decode
    import lcsw_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter logic [7:0]  IO_PAGE = 8'hC0,
    parameter logic [3:0]  SW_NIB  = 4'h8
) (
    input  logic [ADDR_W-1:0] addr,
    output lc_dec_t           dec
);
    localparam int PAGE_LSB = ADDR_W - 8;

    logic page_match;

    always_comb begin
        page_match   = (addr[ADDR_W-1:PAGE_LSB] == IO_PAGE);
        dec.io_hit   = page_match;
        dec.sw_hit   = page_match && (addr[7:4] == SW_NIB);
        dec.bank_sel = addr[3];
        dec.op       = lc_op_e'(addr[1:0]);
        dec.key      = addr[7:0];
    end

    // Bits between the page byte and the low byte stay unused when ADDR_W > 16
    generate
        if (PAGE_LSB > 8) begin : g_mid
            logic unused_mid;
            assign unused_mid = ^addr[PAGE_LSB-1:8];
        end
    endgenerate

endmodule

// File: rtl/lcsw_history.sv
module lcsw_history #(
    parameter int               KEY_W = 8,
    parameter logic [KEY_W-1:0] MASK  = 8'hF3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec,      // valid I/O-page access this cycle
    input  logic             dir_wr,   // 1: write, 0: read
    input  logic [KEY_W-1:0] key,
    output logic             repeat_hit
);
    localparam int N_DIR = 2;

    logic [KEY_W-1:0] last_q [N_DIR];

    generate
        for (genvar g = 0; g < N_DIR; g++) begin : g_dir
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    last_q[g] <= '0;
                end else if (rec && (dir_wr == g[0])) begin
                    last_q[g] <= key;
                end
            end
        end
    endgenerate

    always_comb begin
        repeat_hit = ((last_q[dir_wr] & MASK) == (key & MASK));
    end

endmodule

// File: rtl/lcsw_fsm.sv
module lcsw_fsm
    import lcsw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step,        // valid switch access
    input  lc_op_e op,
    input  logic   bank_sel,
    input  logic   repeat_hit,
    output logic   bank_one,
    output logic   rd_ram,
    output logic   wr_en
);
    lc_state_e state_q, state_d;
    logic      bank_q;

    // Next-state logic
    always_comb begin
        logic arm_ok;
        arm_ok  = wr_en || repeat_hit;
        state_d = state_q;
        if (step) begin
            unique case (op)
                OP_RAM_WP:  state_d = ST_RAM_PROT;                          // T_PROTECT
                OP_ROM_WP:  state_d = ST_ROM_PROT;                          // T_PROTECT
                OP_ROM_ARM: state_d = arm_ok ? ST_ROM_WREN : ST_ROM_PROT;   // T_ARM_*/T_HOLD_WE
                OP_RAM_ARM: state_d = arm_ok ? ST_RAM_WREN : ST_RAM_PROT;   // T_ARM_*/T_HOLD_WE
            endcase
        end
    end

    // State register and bank bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ROM_PROT;
            bank_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (step) begin
                bank_q <= bank_sel;
            end
        end
    end

    // Outputs per state
    always_comb begin
        unique case (state_q)
            ST_ROM_PROT: begin rd_ram = 1'b0; wr_en = 1'b0; end
            ST_RAM_PROT: begin rd_ram = 1'b1; wr_en = 1'b0; end
            ST_ROM_WREN: begin rd_ram = 1'b0; wr_en = 1'b1; end
            ST_RAM_WREN: begin rd_ram = 1'b1; wr_en = 1'b1; end
        endcase
        bank_one = bank_q;
    end

endmodule

// File: rtl/lcsw_ctrl.sv
module lcsw_ctrl
    import lcsw_pkg::*;
#(
    parameter int         ADDR_W  = 16,
    parameter logic [7:0] IO_PAGE = 8'hC0,
    parameter logic [3:0] SW_NIB  = 4'h8,
    parameter logic [7:0] H_MASK  = 8'hF3,
    parameter int         STAT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              bank_one,
    output logic              ram_read_en,
    output logic              ram_write_en,
    output logic [STAT_W-1:0] stat_bank,
    output logic [STAT_W-1:0] stat_ram_rd
);
    localparam logic [STAT_W-1:0] STAT_SET = STAT_W'(1) << (STAT_W - 1);

    lc_dec_t dec;
    logic    repeat_hit;

    lcsw_decode #(
        .ADDR_W (ADDR_W),
        .IO_PAGE(IO_PAGE),
        .SW_NIB (SW_NIB)
    ) u_decode (
        .addr(acc_addr),
        .dec (dec)
    );

    lcsw_history #(
        .KEY_W(8),
        .MASK (H_MASK)
    ) u_history (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec       (acc_valid && dec.io_hit),
        .dir_wr    (acc_write),
        .key       (dec.key),
        .repeat_hit(repeat_hit)
    );

    lcsw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (acc_valid && dec.sw_hit),
        .op        (dec.op),
        .bank_sel  (dec.bank_sel),
        .repeat_hit(repeat_hit),
        .bank_one  (bank_one),
        .rd_ram    (ram_read_en),
        .wr_en     (ram_write_en)
    );

    always_comb begin
        stat_bank   = bank_one    ? '0 : STAT_SET;
        stat_ram_rd = ram_read_en ? STAT_SET : '0;
    end

endmodule

// File: rtl/lcsw_ctrl_chk.sv
module lcsw_ctrl_chk #(
    parameter logic [7:0] IO_PAGE = 8'hC0,
    parameter logic [3:0] SW_NIB  = 4'h8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [7:0] a_page,
    input logic [3:0] a_nib,
    input logic       a_b3,
    input logic [1:0] a_lo,
    input logic       bank_one,
    input logic       ram_read_en,
    input logic       ram_write_en
);
    logic sw_acc;
    assign sw_acc = acc_valid && (a_page == IO_PAGE) && (a_nib == SW_NIB);

    // R1: bank follows bit 3 of the switch address
    p_bank_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sw_acc |=> (bank_one == $past(a_b3)));

    // R2: read source follows bits [1:0]
    p_read_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_acc |=> (ram_read_en == ($past(a_lo[1]) == $past(a_lo[0]))));

    // R3: protect commands drop write permission
    p_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && !a_lo[0]) |=> !ram_write_en);

    // R4: an arm command keeps write permission once held
    p_hold_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_acc && a_lo[0] && ram_write_en) |=> ram_write_en);

    // R7: no switch access, no flag change
    p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_acc |=> ($stable(bank_one) && $stable(ram_read_en) && $stable(ram_write_en)));

    // R4: write permission only rises on an arm command
    p_rise_on_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_write_en) |-> $past(sw_acc && a_lo[0]));

endmodule

bind lcsw_ctrl lcsw_ctrl_chk #(
    .IO_PAGE(IO_PAGE),
    .SW_NIB (SW_NIB)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .a_page      (acc_addr[ADDR_W-1 -: 8]),
    .a_nib       (acc_addr[7:4]),
    .a_b3        (acc_addr[3]),
    .a_lo        (acc_addr[1:0]),
    .bank_one    (bank_one),
    .ram_read_en (ram_read_en),
    .ram_write_en(ram_write_en)
);

// File: tb/test_lcsw_ctrl.sv
module test_lcsw_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = 16'h0000;
    logic        bank_one, ram_read_en, ram_write_en;
    logic [7:0]  stat_bank, stat_ram_rd;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    lcsw_ctrl i_lcsw_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_addr    (acc_addr),
        .bank_one    (bank_one),
        .ram_read_en (ram_read_en),
        .ram_write_en(ram_write_en),
        .stat_bank   (stat_bank),
        .stat_ram_rd (stat_ram_rd)
    );

    // Behavioural reference model
    int m_bank1 = 1, m_rd = 0, m_we = 0;
    int hist_rd = 0, hist_wr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bank1 = 1; m_rd = 0; m_we = 0; hist_rd = 0; hist_wr = 0;
        end else if (acc_valid && acc_addr[15:8] == 8'hC0) begin
            int lo, prev, op;
            lo   = int'(acc_addr[7:0]);
            prev = acc_write ? hist_wr : hist_rd;
            if (lo / 16 == 8) begin
                op      = lo % 4;
                m_bank1 = (lo / 8) % 2;
                m_rd    = (op == 0 || op == 3) ? 1 : 0;
                if (op == 0 || op == 2) m_we = 0;
                else if ((prev & 'hF3) == (lo & 'hF3)) m_we = 1;
            end
            if (acc_write) hist_wr = lo; else hist_rd = lo;
        end
    end

    // R10: per-clock comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_run++;
            if (bank_one !== m_bank1[0] || ram_read_en !== m_rd[0] || ram_write_en !== m_we[0]) begin
                n_fail++;
                $display("FAIL R10 model compare: actual %b%b%b expected %0d%0d%0d",
                         bank_one, ram_read_en, ram_write_en, m_bank1, m_rd, m_we);
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic flags(input string req, input logic b, input logic r, input logic w);
        check(req, {5'd0, bank_one, ram_read_en, ram_write_en}, {5'd0, b, r, w});
    endtask

    task automatic acc(input logic wr, input logic [15:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        flags("R8 reset flags", 1, 0, 0);
        check("R9 reset stat_bank", stat_bank, 8'h00);
        check("R9 reset stat_ram_rd", stat_ram_rd, 8'h00);
        rst_n = 1'b1;

        acc(0, 16'hC088);
        flags("R1 R2 read C088", 1, 1, 0);
        check("R9 stat_ram_rd", stat_ram_rd, 8'h80);
        acc(0, 16'hC080);
        flags("R1 bank2 C080", 0, 1, 0);
        check("R9 stat_bank", stat_bank, 8'h80);

        acc(0, 16'hC083);
        flags("R4 single arm", 0, 1, 0);
        acc(0, 16'hC083);
        flags("R4 double arm", 0, 1, 1);

        acc(0, 16'hC082);
        flags("R3 R2 protect ROM", 0, 0, 0);

        acc(0, 16'hC081);
        acc(0, 16'hC085);
        flags("R4 alias bit2", 0, 0, 1);
        acc(0, 16'hC089);
        flags("R4 hold we bank1", 1, 0, 1);

        acc(1, 16'hC080);
        flags("R3 write protect", 0, 1, 0);

        acc(0, 16'hC08B);
        acc(1, 16'hC08B);
        flags("R5 write breaks nothing", 1, 1, 0);
        acc(0, 16'hC08B);
        flags("R5 read pair across write", 1, 1, 1);

        acc(1, 16'hC080);
        acc(0, 16'hC081);
        acc(0, 16'hC010);
        flags("R7 page access holds flags", 0, 0, 0);
        acc(0, 16'hC081);
        flags("R6 page access breaks pair", 0, 0, 0);

        acc(0, 16'h2345);
        acc(0, 16'hC081);
        flags("R6 off-page not recorded", 0, 0, 1);
        acc(1, 16'hD08A);
        flags("R7 off-page write ignored", 0, 0, 1);

        // R10: no change before the sampling edge
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 16'hC088;
        #1;
        flags("R10 before edge", 0, 0, 1);
        @(negedge clk);
        acc_valid = 1'b0;
        flags("R10 after edge", 1, 1, 0);

        // R7: valid low ignored
        acc_addr = 16'hC082;
        repeat (2) @(negedge clk);
        flags("R7 valid low", 1, 1, 0);

        acc(1, 16'hC083);
        flags("R5 write single", 0, 1, 0);
        acc(1, 16'hC083);
        flags("R5 write pair", 0, 1, 1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule